// File: doc/BRIEF.md
# Filtered Event Trace Recorder

This block keeps a short history of debug events for later inspection. Each event arrives as a type code plus four 32-bit argument words. The block checks the type against a per-type enable mask. An accepted event is stored together with the value of a free-running 64-bit cycle counter, which gives it a timestamp. Storage is a ring of 16 records. When the ring is full, a new event replaces the oldest one, and a sticky flag reports that history was lost.

The read side always shows the oldest record still held. The consumer reads it and then pulses `dismiss` to move on to the next one. A `clear` pulse discards everything at once. The read position is not held in a pointer of its own. It is worked out from the write position and the number of records held, so the only state is the write slot, the count and the overflow flag.

Top module: `evtrace_buf`

## Requirements
- R1: While reset is held, and in the first cycle after it, `count` is 0, `rd_valid` is 0, `overflowed` is 0 and `time_now` is 0.
- R2: An event with `cap_valid`=1 is stored only when bit number `cap_type` of `type_enable` is 1. A disabled type leaves `count` and the read port unchanged.
- R3: A stored record holds the `time_now` value of the cycle in which it was captured, the type code, and `cap_args` unchanged. Argument word k sits in bits [32k+31:32k].
- R4: The read port presents the oldest held record. Records leave in the order they were captured, including across wrap of the 16-slot ring. `rd_valid` is 1 exactly when `count` is nonzero.
- R5: A capture into a full ring (count 16) without a dismiss replaces the oldest record. `count` stays at 16, and the read port then shows the record that was second oldest.
- R6: `dismiss` removes the oldest record and lowers `count` by one. When `count` is 0 it has no effect.
- R7: `clear` makes `count` 0 and lowers `overflowed`. A capture in the same cycle as `clear` survives as the only record. `clear` takes precedence over `dismiss`.
- R8: A capture and a dismiss in the same cycle change `count` by the net amount. At count 16 this keeps 16 records and does not raise `overflowed`.
- R9: `time_now` increases by exactly one every clock cycle after reset.
- R10: `overflowed` rises on the first lost record and stays high until `clear`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_valid | input | 1 | Event offered this cycle |
| cap_type | input | 5 | Event type code |
| cap_args | input | 128 | Four 32-bit argument words, word 0 in the low bits |
| type_enable | input | 32 | Per-type enable mask, bit n enables type n |
| dismiss | input | 1 | Drop the oldest record |
| clear | input | 1 | Discard all records |
| rd_valid | output | 1 | At least one record is held |
| rd_stamp | output | 64 | Timestamp of the oldest record |
| rd_type | output | 5 | Type of the oldest record |
| rd_args | output | 128 | Arguments of the oldest record |
| count | output | 5 | Number of records held, 0 to 16 |
| overflowed | output | 1 | A record was lost since the last clear |
| time_now | output | 64 | Free-running cycle counter |

## Verification
Every capture, dismiss or clear acts at a single clock edge. The read port is a combinational view of the ring, so `count`, `rd_valid`, `overflowed` and the oldest record all show the new state in the cycle right after that edge. The bench drives its inputs at the falling edge and then samples at the next falling edge, one full edge after the inputs were applied. The expected timestamp is the `time_now` value seen when the event was driven, because that value holds throughout the capture cycle. Counter stepping is checked by comparing `time_now` at falling edges a known number of cycles apart.

// File: rtl/evtrace_pkg.sv
package evtrace_pkg;
  parameter int unsigned TS_W   = 64;
  parameter int unsigned TYPE_W = 5;
  parameter int unsigned ARG_W  = 32;
  parameter int unsigned NARG   = 4;

  localparam int unsigned ARGS_W = ARG_W * NARG;
  localparam int unsigned NTYPES = 1 << TYPE_W;

  typedef struct packed {
    logic [TS_W-1:0]   stamp;
    logic [TYPE_W-1:0] kind;
    logic [ARGS_W-1:0] args;
  } evt_rec_t;
endpackage

// File: rtl/evtrace_stamp.sv
module evtrace_stamp #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] stamp_o
);
  logic [W-1:0] stamp_q, stamp_d;

  always_comb begin
    stamp_d = stamp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stamp_q <= '0;
    else        stamp_q <= stamp_d;
  end

  assign stamp_o = stamp_q;
endmodule

// File: rtl/evtrace_ctrl.sv
module evtrace_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             dismiss,
  input  logic             clear,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] head_idx,
  output logic [CNT_W-1:0] count,
  output logic             lost
);
  logic [PTR_W-1:0] wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             drop_ok, full;
  logic [CNT_W:0]   span, span_mod;

  // next state
  always_comb begin
    drop_ok = dismiss && (cnt_q != '0);
    full    = (cnt_q == CNT_W'(DEPTH));
    cnt_d   = cnt_q;
    ovf_d   = ovf_q;
    if (clear) begin
      cnt_d = accept ? CNT_W'(1) : '0;
      ovf_d = 1'b0;
    end else if (accept && !drop_ok) begin
      if (full) ovf_d = 1'b1;
      else      cnt_d = cnt_q + 1'b1;
    end else if (!accept && drop_ok) begin
      cnt_d = cnt_q - 1'b1;
    end
    if (accept) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    else        wr_d = wr_q;
  end

  // oldest slot = write slot minus held count, modulo the ring size
  always_comb begin
    span     = (CNT_W+1)'(wr_q) + (CNT_W+1)'(DEPTH) - {1'b0, cnt_q};
    span_mod = (span >= (CNT_W+1)'(DEPTH)) ? span - (CNT_W+1)'(DEPTH) : span;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign wr_idx   = wr_q;
  assign head_idx = PTR_W'(span_mod);
  assign count    = cnt_q;
  assign lost     = ovf_q;
endmodule

// File: rtl/evtrace_store.sv
module evtrace_store
  import evtrace_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] wr_idx,
  input  evt_rec_t         din,
  input  logic [PTR_W-1:0] rd_idx,
  output evt_rec_t         dout
);
  evt_rec_t slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = we && (wr_idx == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[i] <= din;
    end
  end

  assign dout = slot_q[rd_idx];
endmodule

// File: rtl/evtrace_buf.sv
module evtrace_buf
  import evtrace_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  input  logic [TYPE_W-1:0] cap_type,
  input  logic [ARGS_W-1:0] cap_args,
  input  logic [NTYPES-1:0] type_enable,
  input  logic              dismiss,
  input  logic              clear,
  output logic              rd_valid,
  output logic [TS_W-1:0]   rd_stamp,
  output logic [TYPE_W-1:0] rd_type,
  output logic [ARGS_W-1:0] rd_args,
  output logic [CNT_W-1:0]  count,
  output logic              overflowed,
  output logic [TS_W-1:0]   time_now
);
  logic             accept;
  logic [PTR_W-1:0] wr_idx, head_idx;
  evt_rec_t         wr_rec, rd_rec;

  assign accept = cap_valid && type_enable[cap_type];

  evtrace_stamp #(.W(TS_W)) u_stamp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stamp_o (time_now)
  );

  evtrace_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .dismiss  (dismiss),
    .clear    (clear),
    .wr_idx   (wr_idx),
    .head_idx (head_idx),
    .count    (count),
    .lost     (overflowed)
  );

  always_comb begin
    wr_rec.stamp = time_now;
    wr_rec.kind  = cap_type;
    wr_rec.args  = cap_args;
  end

  evtrace_store #(.DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .we     (accept),
    .wr_idx (wr_idx),
    .din    (wr_rec),
    .rd_idx (head_idx),
    .dout   (rd_rec)
  );

  assign rd_valid = (count != '0);
  assign rd_stamp = rd_rec.stamp;
  assign rd_type  = rd_rec.kind;
  assign rd_args  = rd_rec.args;
endmodule

// File: rtl/evtrace_buf_chk.sv
module evtrace_buf_chk
  import evtrace_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cap_valid,
  input logic [TYPE_W-1:0] cap_type,
  input logic [NTYPES-1:0] type_enable,
  input logic              dismiss,
  input logic              clear,
  input logic              rd_valid,
  input logic [CNT_W-1:0]  count,
  input logic              overflowed,
  input logic [TS_W-1:0]   time_now
);
  logic take;
  assign take = cap_valid && type_enable[cap_type];

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R4

  AST_VALID_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == (count != '0)); // R4

  AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !type_enable[cap_type] && !dismiss && !clear) |=> $stable(count)); // R2

  AST_FULL_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH) && take && !dismiss && !clear) |=> (count == CNT_W'(DEPTH) && overflowed)); // R5

  AST_DISMISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dismiss && !take && !clear && count != '0) |=> (count == $past(count) - 1'b1)); // R6

  AST_DISMISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (dismiss && !take && !clear && count == '0) |=> (count == '0)); // R6

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !take) |=> (count == '0 && !overflowed)); // R7

  AST_NET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dismiss && !clear && count != '0) |=> ($stable(count) && overflowed == $past(overflowed))); // R8

  AST_STAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (time_now == $past(time_now) + 1'b1)); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflowed && !clear) |=> overflowed); // R10
endmodule

bind evtrace_buf evtrace_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cap_valid   (cap_valid),
  .cap_type    (cap_type),
  .type_enable (type_enable),
  .dismiss     (dismiss),
  .clear       (clear),
  .rd_valid    (rd_valid),
  .count       (count),
  .overflowed  (overflowed),
  .time_now    (time_now)
);

// File: tb/test_evtrace_buf.sv
`timescale 1ns/1ps
module test_evtrace_buf;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cap_valid, dismiss, clear;
  logic [4:0]   cap_type;
  logic [127:0] cap_args;
  logic [31:0]  type_enable;
  logic         rd_valid, overflowed;
  logic [63:0]  rd_stamp, time_now;
  logic [4:0]   rd_type, count;
  logic [127:0] rd_args;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  typedef struct packed {
    logic [63:0]  s;
    logic [4:0]   k;
    logic [127:0] a;
  } rec_t;
  rec_t q[$];
  bit   m_ovf = 0;
  int   seq = 0;

  always #4 clk = ~clk;

  evtrace_buf i_evtrace_buf (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_type(cap_type),
    .cap_args(cap_args), .type_enable(type_enable), .dismiss(dismiss),
    .clear(clear), .rd_valid(rd_valid), .rd_stamp(rd_stamp), .rd_type(rd_type),
    .rd_args(rd_args), .count(count), .overflowed(overflowed), .time_now(time_now)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // compare the read side against the reference list
  task automatic cmp(input string req);
    chk({req, " count"}, 128'(count), 128'(q.size()));
    chk({req, " valid"}, 128'(rd_valid), 128'(q.size() != 0));
    chk({req, " ovf"}, 128'(overflowed), 128'(m_ovf));
    if (q.size() != 0) begin
      chk({req, " stamp"}, 128'(rd_stamp), 128'(q[0].s));
      chk({req, " type"}, 128'(rd_type), 128'(q[0].k));
      chk({req, " args"}, rd_args, q[0].a);
    end
  endtask

  function automatic logic [127:0] mk_args(input int n, input logic [4:0] k);
    return {32'(k), 32'(n), ~32'(n), 32'hA500_0000 | 32'(n)};
  endfunction

  // one cycle of stimulus, starting and ending at a falling edge
  task automatic act(input logic v, input logic [4:0] k, input logic d, input logic c);
    rec_t r;
    bit   acc;
    seq++;
    r.s = time_now;
    r.k = k;
    r.a = mk_args(seq, k);
    acc = v && type_enable[k];
    cap_valid = v; cap_type = k; cap_args = r.a; dismiss = d; clear = c;
    @(negedge clk);
    cap_valid = 1'b0; dismiss = 1'b0; clear = 1'b0;
    if (c) begin
      q.delete();
      m_ovf = 0;
    end else if (d && q.size() != 0) begin
      void'(q.pop_front());
    end else if (acc && q.size() == 16) begin
      void'(q.pop_front());
      m_ovf = 1;
    end
    if (acc) q.push_back(r);
  endtask

  task automatic t_reset;
    chk("R1 count", 128'(count), 0);
    chk("R1 valid", 128'(rd_valid), 0);
    chk("R1 ovf", 128'(overflowed), 0);
    chk("R1 time", 128'(time_now), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count after release", 128'(count), 0);
    chk("R9 first step", 128'(time_now), 1);
  endtask

  task automatic t_stamp;
    logic [63:0] t0;
    t0 = time_now;
    repeat (7) @(negedge clk);
    chk("R9 seven cycles", 128'(time_now), 128'(t0 + 64'd7));
  endtask

  task automatic t_filter;
    type_enable = 32'h0000_00A5;
    act(1, 5'd1, 0, 0);  cmp("R2 disabled type 1");
    act(1, 5'd5, 0, 0);  cmp("R2 enabled type 5");
    act(1, 5'd31, 0, 0); cmp("R2 disabled type 31");
    act(1, 5'd7, 0, 0);  cmp("R3 record held");
    act(0, 5'd0, 0, 1);  cmp("R7 clear filter case");
    type_enable = 32'hFFFF_FFFF;
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 16; i++) begin
      act(1, 5'(i + 2), 0, 0);
    end
    cmp("R4 ring full");
    chk("R5 no loss yet", 128'(overflowed), 0);
    act(1, 5'd20, 0, 0); cmp("R5 first overwrite");
    act(1, 5'd21, 0, 0); cmp("R5 second overwrite");
    for (int i = 0; i < 16; i++) begin
      act(0, 5'd0, 1, 0); cmp("R4 drain order");
    end
    act(0, 5'd0, 1, 0); cmp("R6 dismiss when empty");
    chk("R10 flag kept", 128'(overflowed), 1);
  endtask

  task automatic t_clear;
    act(1, 5'd3, 0, 0); act(1, 5'd4, 0, 0); act(1, 5'd6, 0, 0);
    cmp("R4 three held");
    act(0, 5'd0, 0, 1); cmp("R7 clear empties");
    act(1, 5'd9, 0, 1); cmp("R7 capture with clear");
    act(0, 5'd0, 1, 1); cmp("R7 clear with dismiss");
    act(1, 5'd10, 1, 0); cmp("R8 capture and dismiss at empty");
    act(0, 5'd0, 0, 1); cmp("R7 clear again");
  endtask

  task automatic t_net;
    act(1, 5'd11, 0, 0); act(1, 5'd12, 0, 0);
    act(1, 5'd13, 1, 0); cmp("R8 net hold at two");
    for (int i = 0; i < 14; i++) begin
      act(1, 5'(i), 0, 0);
    end
    cmp("R8 refilled");
    act(1, 5'd30, 1, 0); cmp("R8 net hold at full");
    chk("R8 no overflow", 128'(overflowed), 0);
    act(1, 5'd29, 0, 0); cmp("R10 overflow raised");
    act(0, 5'd0, 1, 0); cmp("R10 still set after dismiss");
    act(0, 5'd0, 0, 1); cmp("R10 cleared by clear");
  endtask

  initial begin
    rst_n = 1'b0; cap_valid = 1'b0; dismiss = 1'b0; clear = 1'b0;
    cap_type = '0; cap_args = '0; type_enable = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    t_reset();
    t_stamp();
    t_filter();
    t_wrap();
    t_clear();
    t_net();
    t_stamp();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule